// File: doc/BRIEF.md
# Dual-Channel PWM With Deferred Reprogramming

Two independent pulse-width modulator channels share one register write port. Each channel has its own count enable, a 16-bit interval (period), a 16-bit on-time (duty) and an output inversion bit. While a channel is stopped, a write changes its waveform at once. While it runs, a write lands in a shadow copy and is only adopted when the current cycle finishes, so a running waveform never shows a torn cycle.

A channel can also be armed so that enabling it does not start it. It then waits for a rising edge on its own external start input, which is passed through a synchronizer first. Once a channel runs, further edges on that input do nothing.

Top module: `dual_pwm_shadow`

## Requirements
- R1: After reset every channel is stopped with period, duty and inversion cleared, so every `pwm_o` bit is 0.
- R2: A running channel counts 0 to period-1 and advances by one only on a clock where its `tick_i` bit is 1, so one cycle spans `period` ticks; a period of 0 acts as 1. The count is 0 on the first clock after the channel starts.
- R3: The active level is driven while the count is below duty: duty 0 never drives it, duty at or above the period drives it all the time.
- R4: Inversion bit 1 flips the output; a stopped channel drives the inactive level, i.e. the inversion bit itself.
- R5: Writes to a stopped channel take effect at the clock edge that takes the write.
- R6: Period, duty and inversion writes to a running channel are held and adopted at the edge where the count wraps back to 0.
- R7: `wr_ch_i` picks the channel (0 or 1); a write or tick for one channel leaves the other unchanged.
- R8: `wr_sel_i` codes: 0 period, 1 duty, 2 inversion (data bit 0), 3 control (bit 0 enable, bit 1 start-on-trigger). With start-on-trigger set, an enabled channel stays stopped until a rising edge of its `trig_i` bit; the channel runs from the third clock edge after the input rises.
- R9: `trig_i` edges seen while a channel is disabled or already running have no effect.
- R10: Clearing the enable bit stops the channel at that edge: count back to 0 and output at the inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | 1 | Channel to write |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | 16 | Write data |
| tick_i | input | 2 | Per-channel count enable |
| trig_i | input | 2 | Per-channel asynchronous start input |
| pwm_o | output | 2 | PWM outputs |

## Verification
A wrong count or a period adopted too early shows as an output edge in the wrong clock within one PWM cycle, so each waveform is compared clock by clock over two full cycles for every period, duty and inversion of a small sweep. A shadow value applied at write time rather than at the wrap changes the output in the clock right after the write, which the deferral cases sample. A broken start path shows as an output that leaves the inactive level one clock early or late, or that restarts its count when a second trigger arrives.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_POL    = 2'd2,
    SEL_CTRL   = 2'd3
  } pwm_sel_e;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_SYNC_BIT = 1;
endpackage

// File: rtl/pwm_trig_sync.sv
module pwm_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], trig_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;

  // R8
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel import pwm_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_hit_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tick_i,
  input  logic             trig_rise_i,
  output logic             pwm_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] per_sh_q, per_sh_d, duty_sh_q, duty_sh_d;
  logic             pol_sh_q, pol_sh_d;
  logic [CNT_W-1:0] per_q, duty_q, cnt_q, per_eff;
  logic             pol_q;
  logic             en_q, en_d, sync_q, sync_d;
  logic             running_q, running_d, wrap;
  logic [EXT_W-1:0] cnt_inc;

  always_comb begin
    per_sh_d  = per_sh_q;
    duty_sh_d = duty_sh_q;
    pol_sh_d  = pol_sh_q;
    en_d      = en_q;
    sync_d    = sync_q;
    if (wr_hit_i) begin
      unique case (pwm_sel_e'(wr_sel_i))
        SEL_PERIOD: per_sh_d  = wr_data_i;
        SEL_DUTY:   duty_sh_d = wr_data_i;
        SEL_POL:    pol_sh_d  = wr_data_i[0];
        SEL_CTRL: begin
          en_d   = wr_data_i[CTRL_EN_BIT];
          sync_d = wr_data_i[CTRL_SYNC_BIT];
        end
        default: ;
      endcase
    end
  end

  assign per_eff   = (per_q == '0) ? CNT_W'(1) : per_q;
  assign cnt_inc   = {1'b0, cnt_q} + EXT_W'(1);
  assign wrap      = running_q && tick_i && (cnt_inc >= {1'b0, per_eff});
  // start needs enable; in sync mode also a trigger edge, unless already running
  assign running_d = en_d && (running_q || !sync_d || trig_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_sh_q  <= '0;
      duty_sh_q <= '0;
      pol_sh_q  <= 1'b0;
      per_q     <= '0;
      duty_q    <= '0;
      pol_q     <= 1'b0;
      en_q      <= 1'b0;
      sync_q    <= 1'b0;
      running_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      per_sh_q  <= per_sh_d;
      duty_sh_q <= duty_sh_d;
      pol_sh_q  <= pol_sh_d;
      en_q      <= en_d;
      sync_q    <= sync_d;
      running_q <= running_d;
      if (!running_q || wrap) begin
        per_q  <= per_sh_d;
        duty_q <= duty_sh_d;
        pol_q  <= pol_sh_d;
      end
      if (!running_q || !running_d || wrap) cnt_q <= '0;
      else if (tick_i)                      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  assign pwm_o = (running_q && (cnt_q < duty_q)) ^ pol_q;

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> (cnt_q < per_eff));
  // R6
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && !wrap) |=> ($stable(per_q) && $stable(duty_q) && $stable(pol_q)));
  // R10
  stopped_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (!running_q && cnt_q == '0));
  // R8
  sync_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(running_q) && sync_q) |-> $past(trig_rise_i));
endmodule

// File: rtl/dual_pwm_shadow.sv
module dual_pwm_shadow #(
  parameter int unsigned CH          = 2,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CH_W       = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CH-1:0]    tick_i,
  input  logic [CH-1:0]    trig_i,
  output logic [CH-1:0]    pwm_o
);
  logic [CH-1:0] hit, rise;

  for (genvar g = 0; g < CH; g++) begin : g_ch
    assign hit[g] = wr_en_i && (wr_ch_i == CH_W'(g));

    pwm_trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (trig_i[g]),
      .rise_o (rise[g])
    );

    pwm_channel #(.CNT_W(CNT_W)) i_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_hit_i    (hit[g]),
      .wr_sel_i    (wr_sel_i),
      .wr_data_i   (wr_data_i),
      .tick_i      (tick_i[g]),
      .trig_rise_i (rise[g]),
      .pwm_o       (pwm_o[g])
    );
  end

  // R7
  one_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: tb/test_dual_pwm_shadow.sv
module test_dual_pwm_shadow;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [0:0]  wr_ch_i = '0;
  logic [1:0]  wr_sel_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  tick_i = '0;
  logic [1:0]  trig_i = '0;
  logic [1:0]  pwm_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  dual_pwm_shadow i_dual_pwm_shadow (
    .clk_i, .rst_ni, .wr_en_i, .wr_ch_i, .wr_sel_i, .wr_data_i,
    .tick_i, .trig_i, .pwm_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wr(input int ch, input int sel, input int data);
    wr_en_i   = 1'b1;
    wr_ch_i   = 1'(ch);
    wr_sel_i  = 2'(sel);
    wr_data_i = 16'(data);
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic chk(input string req, input int ch, input logic exp);
    n_chk++;
    if (pwm_o[ch] !== exp) begin
      n_bad++;
      $display("FAIL %s ch%0d: pwm_o=%b expected %b at %0t", req, ch, pwm_o[ch], exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*3);
    // R1
    chk("R1", 0, 1'b0); chk("R1", 1, 1'b0);
    rst_ni = 1'b1;
    tick_i = 2'b11;
    step(); step();
    chk("R1", 0, 1'b0); chk("R1", 1, 1'b0);

    // R2 R3 R4 R5 sweep on channel 0
    for (int p = 0; p <= 6; p++) begin
      for (int d = 0; d <= 7; d++) begin
        for (int pol = 0; pol <= 1; pol++) begin
          int pe;
          pe = (p == 0) ? 1 : p;
          wr(0, 3, 0);
          wr(0, 0, p);
          wr(0, 1, d);
          wr(0, 2, pol);
          chk("R5", 0, 1'(pol));
          wr(0, 3, 1);
          for (int j = 0; j < 2*pe; j++) begin
            chk("R2_R3_R4", 0, 1'(((j % pe) < d) ? 1 : 0) ^ 1'(pol));
            step();
          end
        end
      end
    end

    // R6 period/duty deferral: P=4 D=2 running, then D=3 P=6
    wr(0, 3, 0); wr(0, 0, 4); wr(0, 1, 2); wr(0, 2, 0);
    wr(0, 3, 1);
    wr(0, 1, 3);
    wr(0, 0, 6);
    begin
      logic exp_seq[9] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
      for (int k = 0; k < 9; k++) begin
        chk("R6", 0, exp_seq[k]);
        step();
      end
    end

    // R6 inversion deferral: P=4 D=1
    wr(0, 3, 0); wr(0, 0, 4); wr(0, 1, 1); wr(0, 2, 0);
    wr(0, 3, 1);
    chk("R6", 0, 1'b1);
    wr(0, 2, 1);
    begin
      logic exp_pol[5] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      for (int k = 0; k < 5; k++) begin
        chk("R6", 0, exp_pol[k]);
        step();
      end
    end

    // R10 stop while running
    wr(0, 3, 0); wr(0, 2, 0); wr(0, 0, 5); wr(0, 1, 5);
    wr(0, 3, 1);
    chk("R10", 0, 1'b1);
    step();
    wr(0, 3, 0);
    chk("R10", 0, 1'b0);
    step();
    chk("R10", 0, 1'b0);
    wr(0, 2, 1);
    chk("R5", 0, 1'b1);

    // R2 tick gating on channel 1, R7 channel 0 stays stopped at 1
    tick_i = 2'b00;
    wr(1, 3, 0); wr(1, 0, 3); wr(1, 1, 1); wr(1, 2, 0);
    wr(1, 3, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R2", 1, 1'b1); chk("R7", 0, 1'b1);
      step();
    end
    tick_i[1] = 1'b1; step(); tick_i[1] = 1'b0;
    chk("R2", 1, 1'b0);
    step(); step();
    chk("R2", 1, 1'b0); chk("R7", 0, 1'b1);
    tick_i[1] = 1'b1; step();
    chk("R2", 1, 1'b0);
    step();
    chk("R2", 1, 1'b1); chk("R7", 0, 1'b1);

    // R9 trigger while disabled does nothing
    tick_i = 2'b11;
    wr(1, 3, 0); wr(1, 0, 4); wr(1, 1, 2); wr(1, 2, 0);
    wr(1, 3, 2);
    trig_i[1] = 1'b1; step(); step(); trig_i[1] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R9", 1, 1'b0);
      step();
    end
    // R8 armed channel waits for a trigger edge
    wr(1, 3, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R8", 1, 1'b0);
      step();
    end
    trig_i[1] = 1'b1;
    step(); chk("R8", 1, 1'b0);
    step(); chk("R8", 1, 1'b0);
    step(); chk("R8", 1, 1'b1);
    trig_i[1] = 1'b0;
    step(); chk("R8", 1, 1'b1);
    step(); chk("R8", 1, 1'b0);
    trig_i[1] = 1'b1;
    // R9 second edge while running: count keeps going (k-3 mod 4)
    for (int k = 6; k <= 10; k++) begin
      step();
      chk("R9", 1, 1'(((k - 3) % 4) < 2 ? 1 : 0));
    end
    chk("R7", 0, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule